// File: doc/BRIEF.md
# Logical operation unit with status flags

This unit runs one bitwise operation per accepted request on a byte or word operand pair. The operations are complement, and, inclusive or, exclusive or, and a compare-only and. It returns the result, a write-back enable and a new status-flag vector. A request enters through a valid/ready handshake together with the incoming flag vector. The answer comes out one cycle later on a registered valid/ready output. Operand fetch and instruction decode stay outside the unit.

The flag policy is fixed. The complement operation passes every flag through unchanged. The three combining operations and the compare-only operation clear carry and overflow and drive auxiliary-carry to 0. They derive sign and zero from the result at the selected width, and they derive parity from the low eight result bits only, for both widths. The compare-only operation updates the flags but deasserts write-back.

Back-pressure works as follows. The input is ready whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, all outputs hold still and no new request is taken.

Top module: `logic_unit`

## Requirements
- R1: Opcode 1 gives dst AND src, opcode 2 gives dst OR src and opcode 3 gives dst XOR src, where XOR sets a bit only where the two operand bits differ. Each of the three asserts `wb`.
- R2: For opcodes 1, 2, 3 and 4, carry (flag bit 0) and overflow (flag bit 5) are 0, and auxiliary-carry (flag bit 2) is driven to 0.
- R3: For opcodes 1 to 4, sign (flag bit 4) equals result bit 7 in byte mode and result bit 15 in word mode. Zero (flag bit 3) is 1 exactly when the result at the selected width is zero.
- R4: For opcodes 1 to 4, parity (flag bit 1) is 1 when result bits 7:0 hold an even number of ones, in both byte and word mode.
- R5: Opcode 0 gives the one's complement of dst, asserts `wb` and copies `flags_in` to `flags_out` unchanged.
- R6: Opcode 4 gives dst AND src with flags updated as in R2 to R4, and drives `wb` to 0.
- R7: With `byte_mode` = 1, only bits 7:0 of the operands affect the result and flags, and result bits 15:8 are 0.
- R8: Opcodes 5 to 7 give result 0 and `wb` 0, and copy `flags_in` to `flags_out`.
- R9: Outputs are registered. A request accepted on a clock edge appears with `out_valid` = 1 after that edge. Synchronous reset clears `out_valid`, `result`, `wb` and `flags_out`.
- R10: While `out_valid` = 1 and `out_ready` = 0, `in_ready` is 0 and all outputs stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request |
| op | input | 3 | Operation code (0 NOT, 1 AND, 2 OR, 3 XOR, 4 TEST, 5-7 reserved) |
| byte_mode | input | 1 | 1 selects byte width, 0 selects word width |
| dst | input | 16 | Destination operand |
| src | input | 16 | Source operand |
| flags_in | input | 6 | Current flags {OF,SF,ZF,AF,PF,CF} |
| out_valid | output | 1 | Registered answer present |
| out_ready | input | 1 | Consumer takes the answer |
| result | output | 16 | Operation result |
| wb | output | 1 | Result should be written back |
| flags_out | output | 6 | Updated flags {OF,SF,ZF,AF,PF,CF} |

## Verification
The assertions check several properties on every cycle, relating each accepted request to the registered answer one cycle later. They check that carry and overflow are cleared for the flag-writing operations, that complement and reserved codes pass the flags through, and that the compare-only operation never asserts write-back. They also check that byte mode zeroes the upper result byte and that a stalled output holds still. The exact bit patterns of sign, zero and parity can only be shown by the bench's vectors. These include low-byte parity on a word result whose upper byte is nonzero, and a zero byte result whose discarded upper operand bits are nonzero.

// File: rtl/lu_pkg.sv
package lu_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int NFLAG  = 6;

  localparam logic [2:0] OP_NOT  = 3'd0;
  localparam logic [2:0] OP_AND  = 3'd1;
  localparam logic [2:0] OP_OR   = 3'd2;
  localparam logic [2:0] OP_XOR  = 3'd3;
  localparam logic [2:0] OP_TEST = 3'd4;

  localparam int F_CF = 0;
  localparam int F_PF = 1;
  localparam int F_AF = 2;
  localparam int F_ZF = 3;
  localparam int F_SF = 4;
  localparam int F_OF = 5;

  function automatic logic writes_flags(input logic [2:0] code);
    return (code == OP_AND) || (code == OP_OR) || (code == OP_XOR) || (code == OP_TEST);
  endfunction
endpackage

// File: rtl/lu_operate.sv
module lu_operate #(
  parameter int W  = 16,
  parameter int BW = 8
) (
  input  logic [2:0]   op,
  input  logic         byte_mode,
  input  logic [W-1:0] dst,
  input  logic [W-1:0] src,
  output logic [W-1:0] res,
  output logic         wb
);
  import lu_pkg::*;
  localparam int HI_W = W - BW;

  logic [W-1:0] raw;
  logic [W-1:0] width_mask;

  assign width_mask = byte_mode ? {{HI_W{1'b0}}, {BW{1'b1}}} : {W{1'b1}};

  always_comb begin
    raw = '0;
    wb  = 1'b0;
    unique case (op)
      OP_NOT:  begin raw = ~dst;      wb = 1'b1; end
      OP_AND:  begin raw = dst & src; wb = 1'b1; end
      OP_OR:   begin raw = dst | src; wb = 1'b1; end
      OP_XOR:  begin raw = dst ^ src; wb = 1'b1; end
      OP_TEST: begin raw = dst & src; wb = 1'b0; end
      default: begin raw = '0;        wb = 1'b0; end
    endcase
  end

  assign res = raw & width_mask;
endmodule

// File: rtl/lu_status.sv
module lu_status #(
  parameter int W  = 16,
  parameter int BW = 8,
  parameter int NF = 6
) (
  input  logic [2:0]    op,
  input  logic          byte_mode,
  input  logic [W-1:0]  res,
  input  logic [NF-1:0] flags_in,
  output logic [NF-1:0] flags_out
);
  import lu_pkg::*;

  logic sign_bit;
  logic zero_bit;
  logic even_low;

  assign sign_bit = byte_mode ? res[BW-1] : res[W-1];
  assign zero_bit = (res == '0);
  assign even_low = ~(^res[BW-1:0]);

  always_comb begin
    flags_out = flags_in;
    if (writes_flags(op)) begin
      flags_out[F_CF] = 1'b0;
      flags_out[F_OF] = 1'b0;
      flags_out[F_AF] = 1'b0;
      flags_out[F_SF] = sign_bit;
      flags_out[F_ZF] = zero_bit;
      flags_out[F_PF] = even_low;
    end
  end
endmodule

// File: rtl/lu_hold.sv
module lu_hold #(
  parameter int W  = 16,
  parameter int NF = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic          drain,
  input  logic [W-1:0]  res_d,
  input  logic          wb_d,
  input  logic [NF-1:0] flags_d,
  output logic          vld_q,
  output logic [W-1:0]  res_q,
  output logic          wb_q,
  output logic [NF-1:0] flags_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q   <= 1'b0;
      res_q   <= '0;
      wb_q    <= 1'b0;
      flags_q <= '0;
    end else if (take) begin
      vld_q   <= 1'b1;
      res_q   <= res_d;
      wb_q    <= wb_d;
      flags_q <= flags_d;
    end else if (drain) begin
      vld_q   <= 1'b0;
    end
  end
endmodule

// File: rtl/logic_unit.sv
module logic_unit #(
  parameter int W  = lu_pkg::WORD_W,
  parameter int BW = lu_pkg::BYTE_W,
  parameter int NF = lu_pkg::NFLAG
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    op,
  input  logic          byte_mode,
  input  logic [W-1:0]  dst,
  input  logic [W-1:0]  src,
  input  logic [NF-1:0] flags_in,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  result,
  output logic          wb,
  output logic [NF-1:0] flags_out
);
  logic [W-1:0]  res_c;
  logic          wb_c;
  logic [NF-1:0] flags_c;
  logic          take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  lu_operate #(.W(W), .BW(BW)) u_operate (
    .op(op), .byte_mode(byte_mode), .dst(dst), .src(src),
    .res(res_c), .wb(wb_c)
  );

  lu_status #(.W(W), .BW(BW), .NF(NF)) u_status (
    .op(op), .byte_mode(byte_mode), .res(res_c),
    .flags_in(flags_in), .flags_out(flags_c)
  );

  lu_hold #(.W(W), .NF(NF)) u_hold (
    .clk(clk), .rst(rst), .take(take), .drain(out_ready),
    .res_d(res_c), .wb_d(wb_c), .flags_d(flags_c),
    .vld_q(out_valid), .res_q(result), .wb_q(wb), .flags_q(flags_out)
  );
endmodule

// File: rtl/logic_unit_chk.sv
module logic_unit_chk #(
  parameter int W  = 16,
  parameter int BW = 8,
  parameter int NF = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic [2:0]    op,
  input logic          byte_mode,
  input logic [W-1:0]  dst,
  input logic [W-1:0]  src,
  input logic [NF-1:0] flags_in,
  input logic          out_valid,
  input logic          out_ready,
  input logic [W-1:0]  result,
  input logic          wb,
  input logic [NF-1:0] flags_out
);
  import lu_pkg::*;

  logic acc;
  assign acc = in_valid && in_ready;

  AST_ANSWER_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    acc |=> out_valid); // R9

  AST_AND_WORD: assert property (@(posedge clk) disable iff (rst)
    (acc && op == OP_AND && !byte_mode) |=> (result == ($past(dst) & $past(src)) && wb)); // R1

  AST_CF_OF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (acc && writes_flags(op)) |=> (!flags_out[F_CF] && !flags_out[F_OF] && !flags_out[F_AF])); // R2

  AST_NOT_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (acc && op == OP_NOT) |=> (flags_out == $past(flags_in) && wb)); // R5

  AST_TEST_NO_WB: assert property (@(posedge clk) disable iff (rst)
    (acc && op == OP_TEST) |=> !wb); // R6

  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (acc && byte_mode) |=> (result[W-1:BW] == '0)); // R7

  AST_RESERVED_PASS: assert property (@(posedge clk) disable iff (rst)
    (acc && op > OP_TEST) |=> (result == '0 && !wb && flags_out == $past(flags_in))); // R8

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(result) && $stable(wb) && $stable(flags_out))); // R10

  AST_STALL_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready); // R10
endmodule

bind logic_unit logic_unit_chk #(.W(W), .BW(BW), .NF(NF)) u_chk (.*);

// File: tb/logic_unit_tb.sv
module logic_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_ready;
  logic [2:0]  op;
  logic        byte_mode;
  logic [15:0] dst;
  logic [15:0] src;
  logic [5:0]  flags_in;
  logic        out_valid;
  logic        out_ready;
  logic [15:0] result;
  logic        wb;
  logic [5:0]  flags_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #5 clk = ~clk;

  logic_unit u_dut (.*);

  // {op, byte_mode, dst, src, flags_in, exp_result, exp_wb, exp_flags}; flags {OF,SF,ZF,AF,PF,CF}
  localparam int NV = 11;
  localparam logic [64:0] VEC [NV] = '{
    {3'd1, 1'b0, 16'hF0F0, 16'hFF00, 6'b111111, 16'hF000, 1'b1, 6'b010010}, // R1 R2 R3
    {3'd2, 1'b1, 16'h1234, 16'h0081, 6'b100001, 16'h00B5, 1'b1, 6'b010000}, // R1 R3 R7
    {3'd3, 1'b0, 16'hAAAA, 16'hAAAA, 6'b000000, 16'h0000, 1'b1, 6'b001010}, // R1 R3
    {3'd4, 1'b0, 16'h8001, 16'h0001, 6'b111111, 16'h0001, 1'b0, 6'b000000}, // R6
    {3'd0, 1'b0, 16'h00FF, 16'h1111, 6'b101101, 16'hFF00, 1'b1, 6'b101101}, // R5
    {3'd0, 1'b1, 16'h1234, 16'h0000, 6'b010010, 16'h00CB, 1'b1, 6'b010010}, // R5 R7
    {3'd3, 1'b1, 16'hFF0F, 16'h000F, 6'b000000, 16'h0000, 1'b1, 6'b001010}, // R7
    {3'd1, 1'b0, 16'h0300, 16'hFF03, 6'b000000, 16'h0300, 1'b1, 6'b000010}, // R4
    {3'd2, 1'b0, 16'h0000, 16'h0007, 6'b100001, 16'h0007, 1'b1, 6'b000000}, // R4 R2
    {3'd4, 1'b1, 16'h00F0, 16'h000F, 6'b000000, 16'h0000, 1'b0, 6'b001010}, // R6
    {3'd5, 1'b0, 16'h1234, 16'h5678, 6'b110011, 16'h0000, 1'b0, 6'b110011}  // R8
  };

  function automatic string tag_of(int i);
    case (i)
      0, 1, 2: return "R1";
      3, 9:    return "R6";
      4, 5:    return "R5";
      6:       return "R7";
      7, 8:    return "R4";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic drive(logic [2:0] o, logic b, logic [15:0] d, logic [15:0] s, logic [5:0] f);
    op = o; byte_mode = b; dst = d; src = s; flags_in = f; in_valid = 1'b1;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    op = '0; byte_mode = 1'b0; dst = '0; src = '0; flags_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    check("R9", "reset out_valid", {31'd0, out_valid}, 32'd0);
    check("R9", "reset result", {16'd0, result}, 32'd0);
    check("R9", "reset flags", {26'd0, flags_out}, 32'd0);
    check("R9", "reset wb", {31'd0, wb}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][64:62], VEC[i][61], VEC[i][60:45], VEC[i][44:29], VEC[i][28:23]);
      @(negedge clk);
      in_valid = 1'b0;
      check("R9", "out_valid", {31'd0, out_valid}, 32'd1);
      check(tag_of(i), "result", {16'd0, result}, {16'd0, VEC[i][22:7]});
      check(tag_of(i), "wb", {31'd0, wb}, {31'd0, VEC[i][6]});
      check(tag_of(i), "flags", {26'd0, flags_out}, {26'd0, VEC[i][5:0]});
    end

    @(negedge clk);
    check("R9", "drained out_valid", {31'd0, out_valid}, 32'd0);

    // R10 back-pressure: hold A, offer B
    out_ready = 1'b0;
    drive(3'd1, 1'b0, 16'h0F0F, 16'h00FF, 6'b000000);
    @(negedge clk);
    drive(3'd2, 1'b0, 16'h1000, 16'h0001, 6'b000000);
    check("R10", "stall in_ready", {31'd0, in_ready}, 32'd0);
    check("R10", "first result", {16'd0, result}, 32'h000F);
    @(negedge clk);
    check("R10", "held result", {16'd0, result}, 32'h000F);
    check("R10", "held valid", {31'd0, out_valid}, 32'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10", "second result", {16'd0, result}, 32'h1001);
    check("R10", "second valid", {31'd0, out_valid}, 32'd1);

    // R9 reset clears a held answer
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9", "reset clears valid", {31'd0, out_valid}, 32'd0);
    check("R9", "reset clears result", {16'd0, result}, 32'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule